// File: doc/BRIEF.md
# Search Coprocessor Bus-Cycle Decoder

This block sits between a host processor bus and the array of a memory-mapped search coprocessor. It decides what each bus cycle means. An address-valid input splits the cycles into two kinds. When it is low, the cycle is a random access into the array, and the segment-select input and the address/control bus form the address. When it is high, the cycle carries a control state. Control states are either immediate commands, which go to the array as a one-cycle command strobe, or data transfers. A data transfer loads a configuration or device-select register, or reads or writes one array word.

A configuration bit selects one of two modes. In hardware mode, the address/control bus itself carries the control state, and a transfer completes in the same cycle. In software mode, a control write loads an instruction word from the low data bits. An immediate instruction runs at once. A transfer instruction waits for the next control cycle, which must be of the type the instruction expects. A control read that no instruction is waiting for returns a status word. Each cycle is gated by a device enable. The device enable comes from two active-low chip selects, or from a programmable device-select value that matches the configured page address.

All decode is combinational within the cycle. Registered state changes at the rising clock edge that ends the cycle. The array and the cascade flag logic lie outside this block.

Top module: `cpdec_top`

## Requirements
- R1: When address-valid is low, an enabled cycle is a random access at array address {segSel, acBus}. A write asserts arrWr with dqIn as data and vbIn as the validity bit. A read asserts arrRd and returns arrRdData on dqOut and arrRdVld on vbOut.
- R2: In software mode, a control write with no instruction pending loads the instruction from dqIn[11:0] and the segment from dqIn[12]. The top four instruction bits are its class. Classes 0x1 (config load), 0x2 (device-select load) and 0x5 (array write) expect a write. Class 0x4 (array read) expects a read. An instruction of one of these four classes becomes pending.
- R3: In software mode, an instruction of any other class runs in the cycle it is written. It pulses cmdValid, with cmdCode set to the instruction, cmdSeg set to dqIn[12], and cmdWrite set high when dqIn[13] is low (the same polarity as wrN).
- R4: A control read with nothing pending returns the status word. Its fields are bit 0 error, bit 1 pending, bit 2 software mode, and bits 15:4 the last loaded instruction. The read loads nothing, and it clears the error bit after the cycle.
- R5: A pending transfer completes on the next enabled control cycle of the matching type. For array transfers the address is {segment, 4'b0, instruction[7:0]}. An array read returns the word on dqOut. Completing the transfer clears the pending state.
- R6: A pending transfer met by a control cycle of the wrong type sets the error bit, performs no array access and no register load, and drops the pending state.
- R7: In hardware mode, every enabled control cycle takes its state from acBus and its segment from segSel, and the instruction is recorded as the last loaded instruction. A transfer class completes in the same cycle if the direction matches, and sets the error bit if it does not. An immediate class pulses cmdValid with cmdWrite equal to the write-enable input.
- R8: devEn is high when csN1 or csN2 is low. It is also high when the device-select enable bit (bit 8) is set and the device-select value (bits 3:0) equals the configured page.
- R9: When busEnN is high or devEn is low, a cycle causes no strobe and no state change. dqOe is high only on an enabled read cycle with oeN low, and dqOut is zero whenever dqOe is low.
- R10: A config load takes software mode from bit 0 and the page from bits 7:4 of dqIn.
- R11: After reset the block is in hardware mode, with page 0, the device-select disabled, nothing pending, and a status word of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busEnN | input | 1 | Cycle strobe, active low |
| wrN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| csN1 | input | 1 | Hardware chip select one, active low |
| csN2 | input | 1 | Hardware chip select two, active low |
| addrValid | input | 1 | Low: array address; high: control state |
| segSel | input | 1 | Segment select, the top address bit |
| acBus | input | AC_W | Address/control bus |
| dqIn | input | DQ_W | Data from the processor |
| dqOut | output | DQ_W | Data to the processor |
| dqOe | output | 1 | Drive enable for the data bus |
| vbIn | input | 1 | Validity bit from the processor |
| vbOut | output | 1 | Validity bit to the processor |
| devEn | output | 1 | Device enable |
| arrRd | output | 1 | Array read strobe |
| arrWr | output | 1 | Array write strobe |
| arrAddr | output | AC_W+1 | Array word address |
| arrWrData | output | DQ_W | Array write data |
| arrWrVld | output | 1 | Array write validity bit |
| arrRdData | input | DQ_W | Array read data |
| arrRdVld | input | 1 | Array read validity bit |
| cmdValid | output | 1 | Immediate command strobe |
| cmdCode | output | AC_W | Immediate command code |
| cmdSeg | output | 1 | Immediate command segment |
| cmdWrite | output | 1 | Immediate command write modifier |

## Verification
The hardest case to reach is a software-mode transfer left pending and then met by the wrong cycle type. Reaching it needs a mode switch, an instruction load and then a cycle of the opposite direction, all while the device stays enabled. Directed sequences build each such chain on purpose, and then read status twice to watch the error bit set and clear. Enable through the device-select compare alone is also rare: the chip selects must be high while the compare matches. The bench first programs that register and then lifts both selects. The random phase mixes these paths by drawing instruction classes from a short list, so that loads, mismatches and mode changes recur.

// File: rtl/cpdec_pkg.sv
package cpdec_pkg;

  localparam logic [3:0] CLS_LDCFG  = 4'h1;
  localparam logic [3:0] CLS_LDDSEL = 4'h2;
  localparam logic [3:0] CLS_ARRRD  = 4'h4;
  localparam logic [3:0] CLS_ARRWR  = 4'h5;

  typedef struct packed {
    logic ldCfg;
    logic ldDsel;
    logic arrRd;
    logic arrWr;
    logic xferAddr;
    logic selArr;
    logic dqDrive;
  } ctlStb_t;

  function automatic logic needsData(input logic [3:0] cls);
    return (cls == CLS_LDCFG) || (cls == CLS_LDDSEL) ||
           (cls == CLS_ARRRD) || (cls == CLS_ARRWR);
  endfunction

  function automatic logic wantsWrite(input logic [3:0] cls);
    return cls != CLS_ARRRD;
  endfunction

endpackage

// File: rtl/cpdec_ctrl.sv
module cpdec_ctrl
  import cpdec_pkg::*;
#(
  parameter int AC_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busEnN,
  input  logic            wrN,
  input  logic            oeN,
  input  logic            addrValid,
  input  logic            segSel,
  input  logic [AC_W-1:0] acBus,
  input  logic [AC_W+1:0] dqLow,
  input  logic            devEn,
  input  logic            swMode,
  output ctlStb_t         stb,
  output logic            cmdValid,
  output logic [AC_W-1:0] cmdCode,
  output logic            cmdSeg,
  output logic            cmdWrite,
  output logic            xSeg,
  output logic [AC_W-5:0] xOperand,
  output logic            errFlag,
  output logic            pendFlag,
  output logic [AC_W-1:0] lastInstr
);

  localparam int OP_W = AC_W - 4;

  logic            cycOn, isWr, ctlCyc, memCyc;
  logic            swLoad, swXfer, hwCtl;
  logic [AC_W-1:0] newInstr;
  logic            newSeg, newWrite;
  logic [3:0]      newCls, xCls;
  logic            xferTry, xferOk, mismatch, statusRead;
  logic            pendQ, pendSegQ;
  logic [AC_W-1:0] pendInstrQ;

  assign cycOn  = !busEnN && devEn;
  assign isWr   = !wrN;
  assign ctlCyc = cycOn && addrValid;
  assign memCyc = cycOn && !addrValid;

  assign swLoad = swMode && ctlCyc && !pendQ && isWr;
  assign swXfer = swMode && ctlCyc && pendQ;
  assign hwCtl  = !swMode && ctlCyc;

  assign newInstr = swMode ? dqLow[AC_W-1:0] : acBus;
  assign newSeg   = swMode ? dqLow[AC_W] : segSel;
  assign newWrite = swMode ? !dqLow[AC_W+1] : isWr;
  assign newCls   = newInstr[AC_W-1 -: 4];

  assign xCls     = swXfer ? pendInstrQ[AC_W-1 -: 4] : newCls;
  assign xferTry  = swXfer || (hwCtl && needsData(newCls));
  assign xferOk   = xferTry && (wantsWrite(xCls) == isWr);
  assign mismatch = xferTry && !xferOk;
  assign xSeg     = swXfer ? pendSegQ : newSeg;
  assign xOperand = swXfer ? pendInstrQ[OP_W-1:0] : newInstr[OP_W-1:0];

  assign cmdValid = (swLoad || hwCtl) && !needsData(newCls);
  assign cmdCode  = newInstr;
  assign cmdSeg   = newSeg;
  assign cmdWrite = newWrite;

  always_comb begin
    stb          = '0;
    stb.ldCfg    = xferOk && (xCls == CLS_LDCFG);
    stb.ldDsel   = xferOk && (xCls == CLS_LDDSEL);
    stb.arrWr    = (memCyc && isWr) || (xferOk && (xCls == CLS_ARRWR));
    stb.arrRd    = (memCyc && !isWr) || (xferOk && (xCls == CLS_ARRRD));
    stb.xferAddr = xferOk;
    stb.selArr   = stb.arrRd;
    stb.dqDrive  = cycOn && !isWr && !oeN;
  end

  assign statusRead = ctlCyc && !isWr && !stb.selArr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ      <= 1'b0;
      pendSegQ   <= 1'b0;
      pendInstrQ <= '0;
      lastInstr  <= '0;
      errFlag    <= 1'b0;
    end else begin
      if (swXfer) begin
        pendQ <= 1'b0;
      end else if (swLoad && needsData(newCls)) begin
        pendQ      <= 1'b1;
        pendSegQ   <= newSeg;
        pendInstrQ <= newInstr;
      end
      if (swLoad || hwCtl) lastInstr <= newInstr;
      if (mismatch)        errFlag <= 1'b1;
      else if (statusRead) errFlag <= 1'b0;
    end
  end

  assign pendFlag = pendQ;

  a_r2_pend_set: assert property (@(posedge clk) disable iff (!rstN)
    (swLoad && needsData(newCls)) |=> pendFlag);

  a_r4_read_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (swMode && ctlCyc && !isWr && !pendQ) |=> ($stable(lastInstr) && !pendFlag));

  a_r6_err_set: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |=> (errFlag && !pendFlag));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busEnN || !devEn) |-> (!stb.arrRd && !stb.arrWr && !cmdValid && !stb.dqDrive));

endmodule

// File: rtl/cpdec_dp.sv
module cpdec_dp
  import cpdec_pkg::*;
#(
  parameter int AC_W   = 12,
  parameter int DQ_W   = 32,
  parameter int PAGE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN1,
  input  logic            csN2,
  input  logic            segSel,
  input  logic [AC_W-1:0] acBus,
  input  logic [DQ_W-1:0] dqIn,
  input  logic            vbIn,
  input  logic [DQ_W-1:0] arrRdData,
  input  logic            arrRdVld,
  input  ctlStb_t         stb,
  input  logic            xSeg,
  input  logic [AC_W-5:0] xOperand,
  input  logic            errFlag,
  input  logic            pendFlag,
  input  logic [AC_W-1:0] lastInstr,
  output logic            devEn,
  output logic            swMode,
  output logic [DQ_W-1:0] dqOut,
  output logic            dqOe,
  output logic            vbOut,
  output logic [AC_W:0]   arrAddr,
  output logic [DQ_W-1:0] arrWrData,
  output logic            arrWrVld
);

  localparam int CFG_MODE_BIT = 0;
  localparam int CFG_PAGE_LSB = 4;
  localparam int DSEL_EN_BIT  = 8;
  localparam int ST_LAST_LSB  = 4;

  logic              swModeQ, dselEnQ;
  logic [PAGE_W-1:0] pageQ, dselValQ;
  logic [DQ_W-1:0]   status;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swModeQ  <= 1'b0;
      pageQ    <= '0;
      dselEnQ  <= 1'b0;
      dselValQ <= '0;
    end else begin
      if (stb.ldCfg) begin
        swModeQ <= dqIn[CFG_MODE_BIT];
        pageQ   <= dqIn[CFG_PAGE_LSB +: PAGE_W];
      end
      if (stb.ldDsel) begin
        dselEnQ  <= dqIn[DSEL_EN_BIT];
        dselValQ <= dqIn[PAGE_W-1:0];
      end
    end
  end

  assign swMode = swModeQ;
  assign devEn  = !csN1 || !csN2 || (dselEnQ && (dselValQ == pageQ));

  always_comb begin
    status                          = '0;
    status[0]                       = errFlag;
    status[1]                       = pendFlag;
    status[2]                       = swModeQ;
    status[ST_LAST_LSB +: AC_W]     = lastInstr;
  end

  assign arrAddr   = stb.xferAddr ? {xSeg, 4'b0000, xOperand} : {segSel, acBus};
  assign arrWrData = dqIn;
  assign arrWrVld  = vbIn;

  assign dqOe  = stb.dqDrive;
  assign dqOut = stb.dqDrive ? (stb.selArr ? arrRdData : status) : '0;
  assign vbOut = stb.dqDrive && stb.selArr && arrRdVld;

  a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldCfg |=> (swModeQ == $past(dqIn[CFG_MODE_BIT]) &&
                   pageQ == $past(dqIn[CFG_PAGE_LSB +: PAGE_W])));

  a_r1_mem_addr: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.arrWr || stb.arrRd) && !stb.xferAddr) |-> (arrAddr == {segSel, acBus}));

  a_r8_dsel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldDsel |=> (dselEnQ == $past(dselEnQ) && dselValQ == $past(dselValQ)));

endmodule

// File: rtl/cpdec_top.sv
module cpdec_top
  import cpdec_pkg::*;
#(
  parameter int AC_W   = 12,
  parameter int DQ_W   = 32,
  parameter int PAGE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busEnN,
  input  logic            wrN,
  input  logic            oeN,
  input  logic            csN1,
  input  logic            csN2,
  input  logic            addrValid,
  input  logic            segSel,
  input  logic [AC_W-1:0] acBus,
  input  logic [DQ_W-1:0] dqIn,
  output logic [DQ_W-1:0] dqOut,
  output logic            dqOe,
  input  logic            vbIn,
  output logic            vbOut,
  output logic            devEn,
  output logic            arrRd,
  output logic            arrWr,
  output logic [AC_W:0]   arrAddr,
  output logic [DQ_W-1:0] arrWrData,
  output logic            arrWrVld,
  input  logic [DQ_W-1:0] arrRdData,
  input  logic            arrRdVld,
  output logic            cmdValid,
  output logic [AC_W-1:0] cmdCode,
  output logic            cmdSeg,
  output logic            cmdWrite
);

  ctlStb_t         stb;
  logic            swMode, xSeg, errFlag, pendFlag;
  logic [AC_W-5:0] xOperand;
  logic [AC_W-1:0] lastInstr;

  cpdec_ctrl #(.AC_W(AC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busEnN(busEnN), .wrN(wrN), .oeN(oeN),
    .addrValid(addrValid), .segSel(segSel), .acBus(acBus),
    .dqLow(dqIn[AC_W+1:0]), .devEn(devEn), .swMode(swMode), .stb(stb),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdSeg(cmdSeg), .cmdWrite(cmdWrite),
    .xSeg(xSeg), .xOperand(xOperand), .errFlag(errFlag), .pendFlag(pendFlag),
    .lastInstr(lastInstr)
  );

  cpdec_dp #(.AC_W(AC_W), .DQ_W(DQ_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .csN1(csN1), .csN2(csN2), .segSel(segSel),
    .acBus(acBus), .dqIn(dqIn), .vbIn(vbIn), .arrRdData(arrRdData),
    .arrRdVld(arrRdVld), .stb(stb), .xSeg(xSeg), .xOperand(xOperand),
    .errFlag(errFlag), .pendFlag(pendFlag), .lastInstr(lastInstr),
    .devEn(devEn), .swMode(swMode), .dqOut(dqOut), .dqOe(dqOe), .vbOut(vbOut),
    .arrAddr(arrAddr), .arrWrData(arrWrData), .arrWrVld(arrWrVld)
  );

  assign arrRd = stb.arrRd;
  assign arrWr = stb.arrWr;

endmodule

// File: tb/tb_cpdec_top.sv
`timescale 1ns/1ps
module tb_cpdec_top;
  localparam int AC_W = 12;
  localparam int DQ_W = 32;
  localparam int AW   = AC_W + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic busEnN = 1'b1, wrN = 1'b1, oeN = 1'b1, csN1 = 1'b1, csN2 = 1'b1;
  logic addrValid = 1'b0, segSel = 1'b0, vbIn = 1'b0;
  logic [AC_W-1:0] acBus = '0;
  logic [DQ_W-1:0] dqIn = '0;
  logic [DQ_W-1:0] dqOut, arrWrData, arrRdData;
  logic dqOe, vbOut, devEn, arrRd, arrWr, arrWrVld, arrRdVld;
  logic [AW-1:0] arrAddr;
  logic cmdValid, cmdSeg, cmdWrite;
  logic [AC_W-1:0] cmdCode;

  int tests = 0, fails = 0;
  logic [32:0] mem [0:511];

  // bench model state
  logic mSw = 0, mDEn = 0, mPend = 0, mPSeg = 0, mErr = 0;
  logic [3:0] mPage = 0, mDVal = 0;
  logic [AC_W-1:0] mPInstr = 0, mLast = 0;

  always #2.5 clk = ~clk;

  cpdec_top dut (
    .clk(clk), .rstN(rstN), .busEnN(busEnN), .wrN(wrN), .oeN(oeN),
    .csN1(csN1), .csN2(csN2), .addrValid(addrValid), .segSel(segSel),
    .acBus(acBus), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .vbIn(vbIn),
    .vbOut(vbOut), .devEn(devEn), .arrRd(arrRd), .arrWr(arrWr),
    .arrAddr(arrAddr), .arrWrData(arrWrData), .arrWrVld(arrWrVld),
    .arrRdData(arrRdData), .arrRdVld(arrRdVld), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdSeg(cmdSeg), .cmdWrite(cmdWrite)
  );

  function automatic int idx(input logic [AW-1:0] a);
    return int'({a[AW-1], a[7:0]});
  endfunction

  assign arrRdData = mem[idx(arrAddr)][31:0];
  assign arrRdVld  = mem[idx(arrAddr)][32];

  function automatic logic needs(input logic [3:0] c);
    return c == 4'h1 || c == 4'h2 || c == 4'h4 || c == 4'h5;
  endfunction

  task automatic chk(input string tag, input string fld, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, got, exp);
    end
  endtask

  task automatic runCycle(input logic enN, input logic wN, input logic oN, input logic c1,
                          input logic c2, input logic av, input logic sg,
                          input logic [AC_W-1:0] ac, input logic [DQ_W-1:0] d,
                          input logic vb, input string tag);
    logic eDev, cyc, wr, ctl, memc, sLoad, sX, hw, xtry, xok, xseg, eCmd, eWr, eRd, eOe, nseg, nwr;
    logic [AC_W-1:0] ni;
    logic [3:0] ncls, xcls;
    logic [7:0] xop;
    logic [AW-1:0] eAddr;
    logic [DQ_W-1:0] st, eDq;
    logic eVb;
    @(negedge clk);
    busEnN = enN; wrN = wN; oeN = oN; csN1 = c1; csN2 = c2;
    addrValid = av; segSel = sg; acBus = ac; dqIn = d; vbIn = vb;
    #1;
    eDev = !c1 || !c2 || (mDEn && mDVal == mPage);
    cyc = !enN && eDev; wr = !wN; ctl = cyc && av; memc = cyc && !av;
    ni = mSw ? d[AC_W-1:0] : ac;
    nseg = mSw ? d[AC_W] : sg;
    nwr = mSw ? !d[AC_W+1] : wr;
    ncls = ni[11:8];
    sLoad = mSw && ctl && !mPend && wr;
    sX = mSw && ctl && mPend;
    hw = !mSw && ctl;
    xcls = sX ? mPInstr[11:8] : ncls;
    xtry = sX || (hw && needs(ncls));
    xok = xtry && ((xcls != 4'h4) == wr);
    xseg = sX ? mPSeg : nseg;
    xop = sX ? mPInstr[7:0] : ni[7:0];
    eCmd = (sLoad || hw) && !needs(ncls);
    eWr = (memc && wr) || (xok && xcls == 4'h5);
    eRd = (memc && !wr) || (xok && xcls == 4'h4);
    eAddr = xok ? {xseg, 4'b0000, xop} : {sg, ac};
    eOe = cyc && !wr && !oN;
    st = '0; st[0] = mErr; st[1] = mPend; st[2] = mSw; st[15:4] = mLast;
    eDq = !eOe ? '0 : (eRd ? mem[idx(eAddr)][31:0] : st);
    eVb = eOe && eRd && mem[idx(eAddr)][32];
    chk(tag, "devEn", devEn, eDev);
    chk(tag, "dqOe", dqOe, eOe);
    chk(tag, "dqOut", dqOut, eDq);
    chk(tag, "vbOut", vbOut, eVb);
    chk(tag, "arrRd", arrRd, eRd);
    chk(tag, "arrWr", arrWr, eWr);
    chk(tag, "cmdValid", cmdValid, eCmd);
    if (eRd || eWr) chk(tag, "arrAddr", arrAddr, eAddr);
    if (eWr) begin
      chk(tag, "arrWrData", arrWrData, d);
      chk(tag, "arrWrVld", arrWrVld, vb);
    end
    if (eCmd) begin
      chk(tag, "cmdCode", cmdCode, ni);
      chk(tag, "cmdSeg", cmdSeg, nseg);
      chk(tag, "cmdWrite", cmdWrite, nwr);
    end
    @(posedge clk);
    if (eWr) mem[idx(eAddr)] = {vb, d};
    if (xok && xcls == 4'h1) begin mSw = d[0]; mPage = d[7:4]; end
    if (xok && xcls == 4'h2) begin mDEn = d[8]; mDVal = d[3:0]; end
    if (sX) mPend = 0;
    else if (sLoad && needs(ncls)) begin mPend = 1; mPInstr = ni; mPSeg = nseg; end
    if (sLoad || hw) mLast = ni;
    if (xtry && !xok) mErr = 1;
    else if (ctl && !wr && !eRd) mErr = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] clsList [7];
    logic [DQ_W-1:0] d;
    logic [AC_W-1:0] ac;
    clsList = '{4'h1, 4'h2, 4'h4, 4'h5, 4'h8, 4'hA, 4'h3};
    for (int i = 0; i < 512; i++) mem[i] = {i[0], 32'hA500_0000 ^ (i * 32'h0101_0101)};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state seen at the ports
    chk("R11", "dqOe", dqOe, 0);
    chk("R11", "devEn", devEn, 0);
    chk("R11", "strobes", {arrRd, arrWr, cmdValid}, 3'b000);
    rstN = 1'b1;
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h000, 0, 0, "R11");          // status read is zero
    runCycle(0, 0, 0, 0, 1, 0, 1, 12'h034, 32'hCAFE_0001, 1, "R1");
    runCycle(0, 1, 0, 0, 1, 0, 1, 12'h034, 0, 0, "R1");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h8A5, 0, 0, "R7");           // hw immediate
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h100, 32'h0000_0031, 0, "R10"); // sw on, page 3
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h000, 0, 0, "R4");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_1A5C, 0, "R3");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_2A5C, 0, "R3");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_0200, 0, "R2");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_0103, 0, "R5");
    runCycle(0, 1, 0, 1, 1, 1, 0, 12'h000, 0, 0, "R8");           // enabled by compare
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_1512, 0, "R2");
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h000, 0, 0, "R6");           // wrong type
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h000, 0, 0, "R6");           // error visible
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h000, 0, 0, "R6");           // error cleared
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_1512, 0, "R5");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h1234_5678, 1, "R5");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_1412, 0, "R5");
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h000, 0, 0, "R5");
    runCycle(0, 1, 1, 0, 1, 1, 0, 12'h000, 0, 0, "R9");           // oeN high
    runCycle(1, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_08FF, 0, "R9"); // bus idle
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h000, 0, 0, "R9");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_0100, 0, "R10");
    runCycle(0, 0, 0, 0, 1, 1, 0, 12'h000, 32'h0000_0051, 0, "R10");
    runCycle(0, 1, 0, 1, 1, 1, 0, 12'h000, 0, 0, "R8");           // compare fails
    runCycle(0, 0, 0, 1, 0, 1, 0, 12'h000, 32'h0000_0100, 0, "R8");
    runCycle(0, 0, 0, 1, 0, 1, 0, 12'h000, 32'h0000_0000, 0, "R8"); // back to hw
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h200, 0, 0, "R7");           // hw mismatch
    runCycle(0, 1, 0, 0, 1, 1, 1, 12'h412, 0, 0, "R7");           // hw array read
    runCycle(0, 1, 0, 0, 1, 1, 0, 12'h8C3, 0, 0, "R7");           // hw immediate read
    for (int i = 0; i < 1500; i++) begin
      d = $urandom;
      d[11:8] = clsList[$urandom % 7];
      ac = 12'($urandom);
      ac[11:8] = clsList[$urandom % 7];
      runCycle(($urandom % 10) == 0, $urandom % 2, ($urandom % 8) == 0,
               ($urandom % 3) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
               ac, d, $urandom % 2, "RND");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule